// File: doc/BRIEF.md
# Quantum State-Vector Gate Engine

This block holds the complex amplitude vector of a small quantum register in on-chip storage. It applies one quantum gate per accepted instruction. A single-qubit gate mixes only the two amplitudes whose indices differ in the target bit, so the engine visits those pairs and nothing else. It reads both members of each pair, combines them using only the nonzero matrix entries of the gate, and writes them back. Several pairs can be handled in each clock cycle; the degree of parallelism is a parameter. Arithmetic is signed fixed point with rounding and saturation.

A host fills the vector through the load port while the engine is idle. It then issues one instruction per gate, each carrying an opcode, a target qubit, a control qubit, and, for rotations, precomputed cosine and sine of the half angle. The host waits for `done` before issuing the next gate. At the end it reads the final state through the combinational readout port.

Top module: `qsv_gate_engine`

## Requirements
- R1: After reset every amplitude reads as zero (real and imaginary) and `busy`, `done` and `err` are low.
- R2: With `busy` low, `ld_we` writes `ld_re`/`ld_im` to entry `ld_addr` at the clock edge. The readout port returns the entry at `rd_addr` combinationally. A load request while `busy` is high is ignored.
- R3: Amplitudes, cosine and sine are 20-bit two's complement with 18 fraction bits (1.0 = 262144). Every product is rounded to nearest, with ties rounded upward. Every stored result saturates to the range -524288 to 524287.
- R4: Opcode 0 (X) swaps the pair. Opcode 1 (Y) maps (a, b) to (-i·b, i·a). Opcode 2 (Z) negates b and leaves a unchanged. Here a is the amplitude with target bit 0 and b is its partner with target bit 1.
- R5: Opcode 3 (S) multiplies b by i. Opcode 4 (T) multiplies b by (h + i·h), where h = 185364 is 1/√2 rounded to the format. Neither changes a.
- R6: Opcode 5 (H) sets a to h·(a+b) and b to h·(a−b). The sum and difference are formed at full width before the rounded multiply.
- R7: Opcode 6 (CNOT) swaps a pair only when the control-qubit bit of its indices is 1. All other pairs are left unchanged.
- R8: With c and s taken from the instruction, rotations map (a, b) as follows. Opcode 7 (RX) gives (c·a − i·s·b, c·b − i·s·a). Opcode 8 (RY) gives (c·a − s·b, s·a + c·b). Opcode 9 (RZ) gives ((c − i·s)·a, (c + i·s)·b).
- R9: An instruction is illegal if its opcode is above 9, its target is not below the qubit count, or it is a CNOT whose control equals the target or is not below the qubit count. Such an instruction raises `done` and `err` for one cycle at the edge after it is presented and leaves the state unchanged.
- R10: A legal instruction raises `busy` at the accepting edge. `busy` stays high for exactly 2^(NQ−1)/PAR cycles. `done` pulses on the edge where `busy` falls. Instructions presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Load strobe |
| ld_addr | input | NQ | Amplitude index to load |
| ld_re | input | W | Real part to load |
| ld_im | input | W | Imaginary part to load |
| rd_addr | input | NQ | Amplitude index to read |
| rd_re | output | W | Real part at rd_addr |
| rd_im | output | W | Imaginary part at rd_addr |
| ins_valid | input | 1 | Instruction present |
| ins_op | input | 4 | Gate opcode |
| ins_tgt | input | TW | Target qubit |
| ins_ctl | input | TW | Control qubit (CNOT only) |
| ins_cos | input | W | cos(θ/2) for rotations |
| ins_sin | input | W | sin(θ/2) for rotations |
| busy | output | 1 | Gate being applied |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal instruction flag, with done |

## Verification
With the default six qubits and one pair per cycle, a legal gate finishes 32 edges after the accepting edge. An illegal one finishes on the accepting edge itself. The bench drives on falling edges and counts falling edges from the one after acceptance until `done` is seen, expecting 32 or 0. The amplitudes are read only after that falling edge. Loads take effect at the next rising edge and are read back half a cycle later, since the readout path is combinational.

// File: rtl/qsv_pkg.sv
package qsv_pkg;
   typedef enum logic [3:0] {
      OP_X  = 4'd0,
      OP_Y  = 4'd1,
      OP_Z  = 4'd2,
      OP_S  = 4'd3,
      OP_T  = 4'd4,
      OP_H  = 4'd5,
      OP_CX = 4'd6,
      OP_RX = 4'd7,
      OP_RY = 4'd8,
      OP_RZ = 4'd9
   } qop_e;

   localparam logic [3:0] OP_LAST = 4'd9;
endpackage

// File: rtl/qsv_pair_addr.sv
module qsv_pair_addr #(
   parameter int NQ = 6,
   parameter int TW = 3
) (
   input  logic [NQ-2:0] k,
   input  logic [TW-1:0] tgt,
   output logic [NQ-1:0] i0,
   output logic [NQ-1:0] i1
);
   logic [NQ-1:0] kx, lowm, tbit;

   always_comb begin
      kx   = NQ'(k);
      tbit = NQ'(1) << tgt;
      lowm = tbit - NQ'(1);
      i0   = ((kx & ~lowm) << 1) | (kx & lowm);
      i1   = i0 | tbit;
   end
endmodule

// File: rtl/qsv_pair_lane.sv
module qsv_pair_lane import qsv_pkg::*; #(
   parameter int W    = 20,
   parameter int FRAC = 18
) (
   input  qop_e                op,
   input  logic                swap_en,
   input  logic signed [W-1:0] cos_v,
   input  logic signed [W-1:0] sin_v,
   input  logic signed [W-1:0] a_re,
   input  logic signed [W-1:0] a_im,
   input  logic signed [W-1:0] b_re,
   input  logic signed [W-1:0] b_im,
   output logic signed [W-1:0] na_re,
   output logic signed [W-1:0] na_im,
   output logic signed [W-1:0] nb_re,
   output logic signed [W-1:0] nb_im
);
   localparam int WX = 2*W + 2;
   localparam int HR = $rtoi((2.0**FRAC) * 0.70710678118654752 + 0.5);
   localparam logic signed [WX-1:0] RND  = WX'(1) << (FRAC-1);
   localparam logic signed [WX-1:0] MAXV = (WX'(1) << (W-1)) - WX'(1);
   localparam logic signed [WX-1:0] MINV = -MAXV - WX'(1);
   localparam logic signed [WX-1:0] HX   = WX'(HR);

   function automatic logic signed [WX-1:0] ext(input logic signed [W-1:0] v);
      return WX'(v);
   endfunction

   function automatic logic signed [WX-1:0] fm(input logic signed [WX-1:0] x,
                                                input logic signed [WX-1:0] y);
      logic signed [WX-1:0] p;
      p = x * y;
      p = p + RND;
      return p >>> FRAC;
   endfunction

   function automatic logic signed [W-1:0] sat(input logic signed [WX-1:0] v);
      logic signed [WX-1:0] r;
      if (v > MAXV)      r = MAXV;
      else if (v < MINV) r = MINV;
      else               r = v;
      return r[W-1:0];
   endfunction

   logic signed [WX-1:0] ar, ai, br, bi, c, s;

   always_comb begin
      ar = ext(a_re);
      ai = ext(a_im);
      br = ext(b_re);
      bi = ext(b_im);
      c  = ext(cos_v);
      s  = ext(sin_v);
      na_re = a_re;
      na_im = a_im;
      nb_re = b_re;
      nb_im = b_im;
      case (op)
         OP_X: begin
            na_re = b_re; na_im = b_im; nb_re = a_re; nb_im = a_im;
         end
         OP_Y: begin
            na_re = sat(bi);  na_im = sat(-br);
            nb_re = sat(-ai); nb_im = sat(ar);
         end
         OP_Z: begin
            nb_re = sat(-br); nb_im = sat(-bi);
         end
         OP_S: begin
            nb_re = sat(-bi); nb_im = sat(br);
         end
         OP_T: begin
            nb_re = sat(fm(HX, br) - fm(HX, bi));
            nb_im = sat(fm(HX, br) + fm(HX, bi));
         end
         OP_H: begin
            na_re = sat(fm(HX, ar + br));
            na_im = sat(fm(HX, ai + bi));
            nb_re = sat(fm(HX, ar - br));
            nb_im = sat(fm(HX, ai - bi));
         end
         OP_CX: begin
            if (swap_en) begin
               na_re = b_re; na_im = b_im; nb_re = a_re; nb_im = a_im;
            end
         end
         OP_RX: begin
            na_re = sat(fm(c, ar) + fm(s, bi));
            na_im = sat(fm(c, ai) - fm(s, br));
            nb_re = sat(fm(c, br) + fm(s, ai));
            nb_im = sat(fm(c, bi) - fm(s, ar));
         end
         OP_RY: begin
            na_re = sat(fm(c, ar) - fm(s, br));
            na_im = sat(fm(c, ai) - fm(s, bi));
            nb_re = sat(fm(s, ar) + fm(c, br));
            nb_im = sat(fm(s, ai) + fm(c, bi));
         end
         OP_RZ: begin
            na_re = sat(fm(c, ar) + fm(s, ai));
            na_im = sat(fm(c, ai) - fm(s, ar));
            nb_re = sat(fm(c, br) - fm(s, bi));
            nb_im = sat(fm(c, bi) + fm(s, br));
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/qsv_ctrl.sv
module qsv_ctrl import qsv_pkg::*; #(
   parameter int NQ = 6,
   parameter int TW = 3,
   parameter int W  = 20,
   parameter int CW = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ins_valid,
   input  logic [3:0]          ins_op,
   input  logic [TW-1:0]       ins_tgt,
   input  logic [TW-1:0]       ins_ctl,
   input  logic signed [W-1:0] ins_cos,
   input  logic signed [W-1:0] ins_sin,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [CW-1:0]       grp,
   output qop_e                cur_op,
   output logic [TW-1:0]       cur_tgt,
   output logic [TW-1:0]       cur_ctl,
   output logic signed [W-1:0] cur_cos,
   output logic signed [W-1:0] cur_sin
);
   localparam logic [CW-1:0] LAST = '1;

   logic op_ok, tgt_ok, ctl_ok, legal;

   always_comb begin
      op_ok  = ins_op <= OP_LAST;
      tgt_ok = 32'(ins_tgt) < NQ;
      ctl_ok = (32'(ins_ctl) < NQ) && (ins_ctl != ins_tgt);
      legal  = op_ok && tgt_ok && ((ins_op != 4'(OP_CX)) || ctl_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         grp     <= '0;
         cur_op  <= OP_X;
         cur_tgt <= '0;
         cur_ctl <= '0;
         cur_cos <= '0;
         cur_sin <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (busy) begin
            if (grp == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               grp <= grp + CW'(1);
            end
         end else if (ins_valid) begin
            if (legal) begin
               busy    <= 1'b1;
               grp     <= '0;
               cur_op  <= qop_e'(ins_op);
               cur_tgt <= ins_tgt;
               cur_ctl <= ins_ctl;
               cur_cos <= ins_cos;
               cur_sin <= ins_sin;
            end else begin
               done <= 1'b1;
               err  <= 1'b1;
            end
         end
      end
   end

   AST_END_OF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && !err)); // R10
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !busy)); // R9
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(cur_op) && $stable(cur_tgt) && $stable(cur_cos))); // R10
   AST_LEGAL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (32'(cur_tgt) < NQ)); // R9
endmodule

// File: rtl/qsv_gate_engine.sv
module qsv_gate_engine import qsv_pkg::*; #(
   parameter int NQ   = 6,
   parameter int W    = 20,
   parameter int FRAC = 18,
   parameter int PAR  = 1,
   parameter int TW   = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_we,
   input  logic [NQ-1:0]       ld_addr,
   input  logic signed [W-1:0] ld_re,
   input  logic signed [W-1:0] ld_im,
   input  logic [NQ-1:0]       rd_addr,
   output logic signed [W-1:0] rd_re,
   output logic signed [W-1:0] rd_im,
   input  logic                ins_valid,
   input  logic [3:0]          ins_op,
   input  logic [TW-1:0]       ins_tgt,
   input  logic [TW-1:0]       ins_ctl,
   input  logic signed [W-1:0] ins_cos,
   input  logic signed [W-1:0] ins_sin,
   output logic                busy,
   output logic                done,
   output logic                err
);
   localparam int N     = 1 << NQ;
   localparam int NPAIR = N / 2;
   localparam int PW    = (PAR > 1) ? $clog2(PAR) : 0;
   localparam int CW    = (NQ - 1) - PW;

   generate
      if (NQ < 2 || FRAC >= W - 1 || PAR < 1 || (PAR & (PAR - 1)) != 0
          || PAR > NPAIR / 2 || (1 << TW) < NQ) begin : g_bad_cfg
         $error("qsv_gate_engine: unsupported parameter combination");
      end
   endgenerate

   logic signed [W-1:0] mem_re [N];
   logic signed [W-1:0] mem_im [N];

   logic [CW-1:0]       grp;
   qop_e                cur_op;
   logic [TW-1:0]       cur_tgt, cur_ctl;
   logic signed [W-1:0] cur_cos, cur_sin;

   logic [NQ-1:0]       i0 [PAR];
   logic [NQ-1:0]       i1 [PAR];
   logic signed [W-1:0] nar [PAR];
   logic signed [W-1:0] nai [PAR];
   logic signed [W-1:0] nbr [PAR];
   logic signed [W-1:0] nbi [PAR];

   qsv_ctrl #(.NQ(NQ), .TW(TW), .W(W), .CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_op(ins_op), .ins_tgt(ins_tgt),
      .ins_ctl(ins_ctl), .ins_cos(ins_cos), .ins_sin(ins_sin),
      .busy(busy), .done(done), .err(err), .grp(grp),
      .cur_op(cur_op), .cur_tgt(cur_tgt), .cur_ctl(cur_ctl),
      .cur_cos(cur_cos), .cur_sin(cur_sin)
   );

   for (genvar p = 0; p < PAR; p++) begin : g_lane
      logic [NQ-2:0] k;
      if (PAR == 1) begin : g_single
         assign k = grp;
      end else begin : g_multi
         localparam logic [PW-1:0] LID = PW'(p);
         assign k = {grp, LID};
      end

      qsv_pair_addr #(.NQ(NQ), .TW(TW)) u_addr (
         .k(k), .tgt(cur_tgt), .i0(i0[p]), .i1(i1[p])
      );

      qsv_pair_lane #(.W(W), .FRAC(FRAC)) u_lane (
         .op(cur_op), .swap_en(i0[p][cur_ctl]),
         .cos_v(cur_cos), .sin_v(cur_sin),
         .a_re(mem_re[i0[p]]), .a_im(mem_im[i0[p]]),
         .b_re(mem_re[i1[p]]), .b_im(mem_im[i1[p]]),
         .na_re(nar[p]), .na_im(nai[p]), .nb_re(nbr[p]), .nb_im(nbi[p])
      );

      AST_PAIR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
         busy |-> ($countones(i0[p] ^ i1[p]) == 1 && !i0[p][cur_tgt])); // R4
      AST_CX_CTL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && cur_op == OP_CX) |-> (i0[p][cur_ctl] == i1[p][cur_ctl])); // R7
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            mem_re[i] <= '0;
            mem_im[i] <= '0;
         end
      end else if (busy) begin
         for (int p = 0; p < PAR; p++) begin
            mem_re[i0[p]] <= nar[p];
            mem_im[i0[p]] <= nai[p];
            mem_re[i1[p]] <= nbr[p];
            mem_im[i1[p]] <= nbi[p];
         end
      end else if (ld_we) begin
         mem_re[ld_addr] <= ld_re;
         mem_im[ld_addr] <= ld_im;
      end
   end

   assign rd_re = mem_re[rd_addr];
   assign rd_im = mem_im[rd_addr];

   AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ld_we && cur_op == OP_Z && ld_addr[cur_tgt] == 1'b0)
      |=> ($stable(mem_re[$past(ld_addr)]) && $stable(mem_im[$past(ld_addr)]))); // R2
endmodule

// File: tb/sim_qsv_gate_engine.sv
module sim_qsv_gate_engine;
   localparam int NQ = 6;
   localparam int N  = 64;
   localparam int W  = 20;
   localparam int TW = 3;
   localparam int LAT = 32;
   localparam longint HC = 185364;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_we = 1'b0;
   logic [NQ-1:0] ld_addr = '0;
   logic signed [W-1:0] ld_re = '0, ld_im = '0;
   logic [NQ-1:0] rd_addr = '0;
   logic signed [W-1:0] rd_re, rd_im;
   logic ins_valid = 1'b0;
   logic [3:0] ins_op = '0;
   logic [TW-1:0] ins_tgt = '0, ins_ctl = '0;
   logic signed [W-1:0] ins_cos = '0, ins_sin = '0;
   logic busy, done, err;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   longint mre [N];
   longint mim [N];

   always #10 clk = ~clk;

   qsv_gate_engine u0 (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
      .ld_re(ld_re), .ld_im(ld_im), .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im),
      .ins_valid(ins_valid), .ins_op(ins_op), .ins_tgt(ins_tgt), .ins_ctl(ins_ctl),
      .ins_cos(ins_cos), .ins_sin(ins_sin), .busy(busy), .done(done), .err(err)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL R10 watchdog expired: actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic check(input string tag, input longint got, input longint exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   function automatic longint fm(input longint x, input longint y);
      return (x * y + 131072) >>> 18;
   endfunction

   function automatic longint sat(input longint v);
      if (v > 524287) return 524287;
      if (v < -524288) return -524288;
      return v;
   endfunction

   // Reference gate model written from R3..R8
   task automatic model(input int op, input int t, input int c, input longint co, input longint si);
      for (int i = 0; i < N; i++) begin
         if (((i >> t) & 1) == 0) begin
            int j;
            longint ar, ai, br, bi, xr, xi, yr, yi;
            j = i | (1 << t);
            ar = mre[i]; ai = mim[i]; br = mre[j]; bi = mim[j];
            xr = ar; xi = ai; yr = br; yi = bi;
            case (op)
               0: begin xr = br; xi = bi; yr = ar; yi = ai; end
               1: begin xr = sat(bi); xi = sat(-br); yr = sat(-ai); yi = sat(ar); end
               2: begin yr = sat(-br); yi = sat(-bi); end
               3: begin yr = sat(-bi); yi = sat(br); end
               4: begin yr = sat(fm(HC, br) - fm(HC, bi)); yi = sat(fm(HC, br) + fm(HC, bi)); end
               5: begin
                  xr = sat(fm(HC, ar + br)); xi = sat(fm(HC, ai + bi));
                  yr = sat(fm(HC, ar - br)); yi = sat(fm(HC, ai - bi));
               end
               6: if (((i >> c) & 1) == 1) begin xr = br; xi = bi; yr = ar; yi = ai; end
               7: begin
                  xr = sat(fm(co, ar) + fm(si, bi)); xi = sat(fm(co, ai) - fm(si, br));
                  yr = sat(fm(co, br) + fm(si, ai)); yi = sat(fm(co, bi) - fm(si, ar));
               end
               8: begin
                  xr = sat(fm(co, ar) - fm(si, br)); xi = sat(fm(co, ai) - fm(si, bi));
                  yr = sat(fm(si, ar) + fm(co, br)); yi = sat(fm(si, ai) + fm(co, bi));
               end
               9: begin
                  xr = sat(fm(co, ar) + fm(si, ai)); xi = sat(fm(co, ai) - fm(si, ar));
                  yr = sat(fm(co, br) - fm(si, bi)); yi = sat(fm(co, bi) + fm(si, br));
               end
               default: ;
            endcase
            mre[i] = xr; mim[i] = xi; mre[j] = yr; mim[j] = yi;
         end
      end
   endtask

   task automatic load(input int a, input longint re, input longint im);
      ld_we = 1'b1; ld_addr = NQ'(a); ld_re = W'(re); ld_im = W'(im);
      @(negedge clk);
      ld_we = 1'b0;
      mre[a] = re; mim[a] = im;
   endtask

   task automatic run(input int op, input int t, input int c, input longint co, input longint si,
                      output int lat, output logic e);
      ins_valid = 1'b1; ins_op = 4'(op); ins_tgt = TW'(t); ins_ctl = TW'(c);
      ins_cos = W'(co); ins_sin = W'(si);
      @(negedge clk);
      ins_valid = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      e = err;
   endtask

   task automatic check_state(input string tag);
      for (int i = 0; i < N; i++) begin
         rd_addr = NQ'(i);
         #1;
         check($sformatf("%s re[%0d]", tag, i), longint'(rd_re), mre[i]);
         check($sformatf("%s im[%0d]", tag, i), longint'(rd_im), mim[i]);
      end
   endtask

   // {op, tgt, ctl, cos, sin}
   localparam logic [49:0] VEC [11] = '{
      {4'd5, 3'd0, 3'd0, 20'sd0, 20'sd0},           // R6 H
      {4'd0, 3'd3, 3'd0, 20'sd0, 20'sd0},           // R4 X
      {4'd1, 3'd5, 3'd0, 20'sd0, 20'sd0},           // R4 Y
      {4'd2, 3'd1, 3'd0, 20'sd0, 20'sd0},           // R4 Z
      {4'd3, 3'd2, 3'd0, 20'sd0, 20'sd0},           // R5 S
      {4'd4, 3'd4, 3'd0, 20'sd0, 20'sd0},           // R5 T
      {4'd6, 3'd2, 3'd0, 20'sd0, 20'sd0},           // R7 CNOT
      {4'd7, 3'd1, 3'd0, 20'sd230054, 20'sd125682}, // R8 RX
      {4'd8, 3'd5, 3'd0, 20'sd141636, 20'sd220586}, // R8 RY
      {4'd9, 3'd0, 3'd0, 20'sd250436, 20'sd77470},  // R8 RZ
      {4'd5, 3'd5, 3'd0, 20'sd0, 20'sd0}            // R6 H
   };

   initial begin
      int lat;
      logic e;
      for (int i = 0; i < N; i++) begin mre[i] = 0; mim[i] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy", longint'(busy), 0);
      check("R1 done", longint'(done), 0);
      check("R1 err", longint'(err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");

      // R2: load and readout
      for (int i = 0; i < N; i++) load(i, i * 7919 - 250000, 180000 - i * 5501);
      check_state("R2 load");

      // Vector table walk: R4..R8 and R10 latency
      foreach (VEC[v]) begin
         int op, t, c;
         longint co, si;
         op = int'(VEC[v][49:46]); t = int'(VEC[v][45:43]); c = int'(VEC[v][42:40]);
         co = longint'($signed(VEC[v][39:20])); si = longint'($signed(VEC[v][19:0]));
         run(op, t, c, co, si, lat, e);
         check($sformatf("R10 latency op%0d", op), lat, LAT);
         check($sformatf("R9 err op%0d", op), longint'(e), 0);
         model(op, t, c, co, si);
         check_state($sformatf("R4-8 vec%0d op%0d", v, op));
      end

      // R2 load ignored while busy, R10 instruction ignored while busy
      ins_valid = 1'b1; ins_op = 4'd0; ins_tgt = 3'd0;
      @(negedge clk);
      ins_op = 4'd2; ins_tgt = 3'd3;
      ld_we = 1'b1; ld_addr = 6'd5; ld_re = 20'sd7; ld_im = 20'sd9;
      @(negedge clk);
      ins_valid = 1'b0; ld_we = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      check("R10 busy-ignore latency", lat, LAT);
      repeat (3) @(negedge clk);
      check("R10 second ins ignored busy", longint'(busy), 0);
      model(0, 0, 0, 0, 0);
      check_state("R2 R10 busy-ignore");

      // R9 illegal instructions
      run(15, 0, 0, 0, 0, lat, e);
      check("R9 bad op latency", lat, 0);
      check("R9 bad op err", longint'(e), 1);
      run(1, 6, 0, 0, 0, lat, e);
      check("R9 bad tgt err", longint'(e), 1);
      run(6, 2, 2, 0, 0, lat, e);
      check("R9 cx ctl==tgt err", longint'(e), 1);
      run(6, 2, 7, 0, 0, lat, e);
      check("R9 cx ctl range err", longint'(e), 1);
      check_state("R9 unchanged");

      // R3 rounding: T on b=(1,0) gives (1,1) by round-to-nearest
      load(0, 0, 0);
      load(1, 1, 0);
      run(4, 0, 0, 0, 0, lat, e);
      model(4, 0, 0, 0, 0);
      rd_addr = 6'd1; #1;
      check("R3 round re", longint'(rd_re), 1);
      check("R3 round im", longint'(rd_im), 1);

      // R3 saturation: H on two max values, Y negating the minimum
      load(0, 524287, 0);
      load(1, 524287, 0);
      load(2, 0, -524288);
      load(3, 0, 0);
      run(5, 0, 0, 0, 0, lat, e);
      model(5, 0, 0, 0, 0);
      rd_addr = 6'd0; #1;
      check("R3 sat H", longint'(rd_re), 524287);
      load(2, 0, -524288);
      load(3, 0, 0);
      run(1, 0, 0, 0, 0, lat, e);
      model(1, 0, 0, 0, 0);
      rd_addr = 6'd3; #1;
      check("R3 sat Y", longint'(rd_re), 524287);
      check_state("R3 final");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule